// File: doc/BRIEF.md
# Viterbi Arc Relaxation Unit

This block carries out the compare-and-select step of a Viterbi beam search over a recognition network. Active arcs arrive one per cycle on a valid/ready stream. Each arc carries the cost of its source state, an observation score and a transition weight. The unit adds the three terms, with the sum saturating at the all-ones cost. It then lowers the cost of the arc's destination state in a local cost table, but only when the new value beats the stored one. A candidate above the beam limit is dropped outright.

Each arc is relaxed on its own, so several arcs may converge on one destination. A two-stage pipeline does the work. Stage one reads the stored cost. Stage two compares and writes. When two consecutive arcs share a destination, the pending write is forwarded to the read of the second arc, so the table behaves like an atomic minimum and no update is lost. A frame-start pulse resets every stored cost to the maximum in one cycle. The first time a destination is lowered within a frame, its index is emitted once on an active-state output. A read port gives the present cost of any state.

Top module: `arc_relax_unit`

## Requirements
- R1: After reset every state reads the maximum cost (all ones, 16 bits), `arc_ready` is high and `act_valid` stays low.
- R2: An accepted arc forms the candidate src + obs + weight and stores it at `arc_dst` when it is lower than the stored cost.
- R3: The candidate sum saturates at the maximum cost. A saturated candidate never changes a state and never activates it.
- R4: A candidate equal to or greater than the stored cost leaves that cost unchanged.
- R5: Arcs to the same destination on consecutive cycles, or interleaved with other destinations, leave the minimum of all their candidates with no lost update.
- R6: A candidate strictly above `beam_limit` is discarded: no write and no activation. A candidate equal to `beam_limit` is kept.
- R7: The first lowering of a state within a frame pulses `act_valid` for one cycle with `act_state` equal to that state. Later lowerings in the same frame do not pulse.
- R8: A `frame_start` pulse holds `arc_ready` low for that cycle, cancels the arc in flight, resets every cost to the maximum and re-arms activation for all states.
- R9: An arc accepted at clock edge k changes `peek_cost` and raises `act_valid` after edge k+1, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Starts a new frame: resets costs and active flags |
| beam_limit | input | 16 | Largest candidate cost still kept |
| arc_valid | input | 1 | Arc present on the input stream |
| arc_ready | output | 1 | Unit can take an arc this cycle |
| arc_src_cost | input | 16 | Cost of the arc's source state |
| arc_obs_cost | input | 16 | Observation score of the arc |
| arc_weight | input | 16 | Transition weight of the arc |
| arc_dst | input | 4 | Destination state index |
| act_valid | output | 1 | One-cycle pulse: a state became active |
| act_state | output | 4 | Index of the newly active state |
| peek_addr | input | 4 | State index to read |
| peek_cost | output | 16 | Present cost of state `peek_addr` |

## Verification
Single arcs to fresh states establish the sum, the two-edge latency and the activation pulse. Arcs that are better, equal and worse against an occupied state separate a strict minimum from overwrite-on-equal behaviour. Back-to-back and interleaved bursts to shared destinations expose any stale read that the forwarding path should cover. Candidates placed at, and one above, the beam limit and the saturation point check both boundaries. A frame start issued with an arc still in flight shows whether that arc is cancelled and whether activation is re-armed.

// File: rtl/arc_relax_pkg.sv
package arc_relax_pkg;

    localparam int COST_W   = 16;
    localparam int N_STATES = 16;
    localparam int ST_W     = $clog2(N_STATES);
    localparam int SUM_W    = COST_W + 2;

    localparam logic [COST_W-1:0] COST_MAX = '1;

    typedef logic [COST_W-1:0] cost_t;
    typedef logic [ST_W-1:0]   st_t;

    // Contents of the read stage, consumed by the compare/write stage
    typedef struct packed {
        logic  v;
        st_t   dst;
        cost_t cand;
        cost_t old_cost;
        logic  old_hit;
    } relax_s1_t;

    function automatic cost_t sat_sum3(cost_t a, cost_t b, cost_t c);
        logic [SUM_W-1:0] s;
        s = {2'b00, a} + {2'b00, b} + {2'b00, c};
        return (s > {2'b00, COST_MAX}) ? COST_MAX : s[COST_W-1:0];
    endfunction

endpackage

// File: rtl/relax_cand_calc.sv
module relax_cand_calc
    import arc_relax_pkg::*;
(
    input  logic [COST_W-1:0] src_cost,
    input  logic [COST_W-1:0] obs_cost,
    input  logic [COST_W-1:0] weight,
    output logic [COST_W-1:0] cand
);
    always_comb cand = sat_sum3(src_cost, obs_cost, weight);
endmodule

// File: rtl/relax_cmp_sel.sv
module relax_cmp_sel
    import arc_relax_pkg::*;
(
    input  logic              valid,
    input  logic [COST_W-1:0] cand,
    input  logic [COST_W-1:0] old_cost,
    input  logic [COST_W-1:0] limit,
    output logic              win,
    output logic [COST_W-1:0] new_cost
);
    always_comb begin
        win      = valid && (cand < old_cost) && (cand <= limit);
        new_cost = win ? cand : old_cost;
    end
endmodule

// File: rtl/relax_cost_store.sv
module relax_cost_store
    import arc_relax_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              we,
    input  logic [ST_W-1:0]   waddr,
    input  logic [COST_W-1:0] wdata,
    input  logic [ST_W-1:0]   raddr_a,
    output logic [COST_W-1:0] rcost_a,
    output logic              rhit_a,
    input  logic [ST_W-1:0]   raddr_b,
    output logic [COST_W-1:0] rcost_b
);
    cost_t               cost_q [N_STATES];
    logic [N_STATES-1:0] hit_q;

    // A state not written in this frame reads as the maximum cost
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hit_q <= '0;
        end else if (we) begin
            hit_q[waddr] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (we && !clear) begin
            cost_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rhit_a  = hit_q[raddr_a];
        rcost_a = hit_q[raddr_a] ? cost_q[raddr_a] : COST_MAX;
        rcost_b = hit_q[raddr_b] ? cost_q[raddr_b] : COST_MAX;
    end
endmodule

// File: rtl/arc_relax_unit.sv
module arc_relax_unit
    import arc_relax_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic [COST_W-1:0] beam_limit,
    input  logic              arc_valid,
    output logic              arc_ready,
    input  logic [COST_W-1:0] arc_src_cost,
    input  logic [COST_W-1:0] arc_obs_cost,
    input  logic [COST_W-1:0] arc_weight,
    input  logic [ST_W-1:0]   arc_dst,
    output logic              act_valid,
    output logic [ST_W-1:0]   act_state,
    input  logic [ST_W-1:0]   peek_addr,
    output logic [COST_W-1:0] peek_cost
);
    relax_s1_t s1_q, s1_d;
    cost_t     cand_in, rd_cost, new_cost;
    logic      rd_hit, win, accept, fwd, we;
    logic      act_valid_q;
    st_t       act_state_q;

    assign arc_ready = ~frame_start;
    assign accept    = arc_valid & arc_ready;

    relax_cand_calc u_cand (
        .src_cost (arc_src_cost),
        .obs_cost (arc_obs_cost),
        .weight   (arc_weight),
        .cand     (cand_in)
    );

    relax_cmp_sel u_cmp (
        .valid    (s1_q.v),
        .cand     (s1_q.cand),
        .old_cost (s1_q.old_cost),
        .limit    (beam_limit),
        .win      (win),
        .new_cost (new_cost)
    );

    assign we = win & ~frame_start;

    relax_cost_store u_store (
        .clk     (clk),
        .rst     (rst),
        .clear   (frame_start),
        .we      (we),
        .waddr   (s1_q.dst),
        .wdata   (s1_q.cand),
        .raddr_a (arc_dst),
        .rcost_a (rd_cost),
        .rhit_a  (rd_hit),
        .raddr_b (peek_addr),
        .rcost_b (peek_cost)
    );

    // Forward the result of the compare stage when it targets the same state
    always_comb begin
        fwd           = s1_q.v && (s1_q.dst == arc_dst);
        s1_d.v        = accept;
        s1_d.dst      = arc_dst;
        s1_d.cand     = cand_in;
        s1_d.old_cost = fwd ? new_cost : rd_cost;
        s1_d.old_hit  = fwd ? (s1_q.old_hit | win) : rd_hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q        <= '0;
            act_valid_q <= 1'b0;
            act_state_q <= '0;
        end else begin
            s1_q        <= s1_d;
            act_valid_q <= we & ~s1_q.old_hit;
            act_state_q <= s1_q.dst;
        end
    end

    assign act_valid = act_valid_q;
    assign act_state = act_state_q;
endmodule

// File: rtl/arc_relax_unit_chk.sv
module arc_relax_unit_chk
    import arc_relax_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              frame_start,
    input logic [COST_W-1:0] beam_limit,
    input logic              arc_valid,
    input logic              arc_ready,
    input logic [COST_W-1:0] arc_src_cost,
    input logic [COST_W-1:0] arc_obs_cost,
    input logic [COST_W-1:0] arc_weight,
    input logic [ST_W-1:0]   arc_dst,
    input logic              act_valid,
    input logic [ST_W-1:0]   act_state,
    input logic [ST_W-1:0]   peek_addr,
    input logic [COST_W-1:0] peek_cost
);
    logic  took;
    cost_t sum_in;
    assign took   = arc_valid && arc_ready;
    assign sum_in = sat_sum3(arc_src_cost, arc_obs_cost, arc_weight);

    // R1
    rst_quiet_chk: assert property (@(posedge clk) rst |=> !act_valid);

    // R8
    frame_kill_chk: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> !act_valid);

    // R6
    beam_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (took && sum_in > beam_limit) |-> ##2 !act_valid);

    // R3
    sat_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (took && sum_in == COST_MAX) |-> ##2 !act_valid);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !took |-> ##2 !act_valid);

    // R7
    single_push_chk: assert property (@(posedge clk) disable iff (rst)
        act_valid |=> !(act_valid && act_state == $past(act_state)));
endmodule

bind arc_relax_unit arc_relax_unit_chk u_chk (.*);

// File: tb/arc_relax_unit_tb.sv
module arc_relax_unit_tb;
    import arc_relax_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_start = 1'b0;
    cost_t       beam_limit = COST_MAX;
    logic        arc_valid = 1'b0;
    logic        arc_ready;
    cost_t       arc_src_cost = '0, arc_obs_cost = '0, arc_weight = '0;
    st_t         arc_dst = '0;
    logic        act_valid;
    st_t         act_state;
    st_t         peek_addr = '0;
    cost_t       peek_cost;

    int n_checks = 0;
    int n_fail   = 0;
    int pushes [N_STATES];

    always #2 clk = ~clk;

    arc_relax_unit u_dut (.*);

    // Record activation pulses away from the clock edge
    always @(negedge clk) begin
        if (!rst && act_valid) pushes[act_state] = pushes[act_state] + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic peek(input int st, output int c);
        peek_addr = st_t'(st);
        #1;
        c = int'(peek_cost);
    endtask

    task automatic put_arc(input int s, input int o, input int w, input int d);
        @(negedge clk);
        arc_valid    = 1'b1;
        arc_src_cost = cost_t'(s);
        arc_obs_cost = cost_t'(o);
        arc_weight   = cost_t'(w);
        arc_dst      = st_t'(d);
    endtask

    task automatic end_arcs();
        @(negedge clk);
        arc_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        int c;
        for (int i = 0; i < N_STATES; i++) begin
            peek(i, c);
            chk("R1 cost after reset", c, 65535);
        end
        chk("R1 ready after reset", int'(arc_ready), 1);
        chk("R1 no pushes", pushes[0] + pushes[5], 0);
    endtask

    task automatic t_basic();
        int c;
        put_arc(10, 20, 5, 3);
        @(negedge clk);
        arc_valid = 1'b0;
        peek(3, c);
        chk("R9 not yet written", c, 65535);
        chk("R9 no early push", int'(act_valid), 0);
        @(negedge clk);
        peek(3, c);
        chk("R2 sum stored", c, 35);
        chk("R9 push visible", int'(act_valid), 1);
        chk("R7 push state", int'(act_state), 3);
        chk("R7 one push", pushes[3], 1);
    endtask

    task automatic t_minimum();
        int c;
        put_arc(40, 0, 0, 3);
        end_arcs();
        peek(3, c);
        chk("R4 worse ignored", c, 35);
        put_arc(30, 5, 0, 3);
        end_arcs();
        peek(3, c);
        chk("R4 equal ignored", c, 35);
        put_arc(10, 5, 5, 3);
        end_arcs();
        peek(3, c);
        chk("R2 better stored", c, 20);
        chk("R7 no second push", pushes[3], 1);
    endtask

    task automatic t_beam();
        int c;
        beam_limit = 16'd100;
        put_arc(50, 50, 1, 5);
        end_arcs();
        peek(5, c);
        chk("R6 above limit dropped", c, 65535);
        chk("R6 no push above limit", pushes[5], 0);
        put_arc(50, 25, 25, 6);
        end_arcs();
        peek(6, c);
        chk("R6 at limit kept", c, 100);
        chk("R6 push at limit", pushes[6], 1);
        beam_limit = COST_MAX;
    endtask

    task automatic t_saturate();
        int c;
        put_arc(16'hFFF0, 16'h0020, 0, 7);
        end_arcs();
        peek(7, c);
        chk("R3 saturated ignored", c, 65535);
        chk("R3 no push on saturation", pushes[7], 0);
        put_arc(16'hFFFE, 0, 0, 8);
        end_arcs();
        peek(8, c);
        chk("R3 just below max kept", c, 65534);
    endtask

    task automatic t_hazard();
        int c;
        put_arc(50, 0, 0, 9);
        put_arc(30, 0, 0, 9);
        put_arc(40, 0, 0, 9);
        put_arc(30, 0, 0, 10);
        put_arc(50, 0, 0, 10);
        put_arc(60, 0, 0, 11);
        put_arc(70, 0, 0, 12);
        put_arc(45, 0, 0, 11);
        end_arcs();
        peek(9, c);
        chk("R5 burst min", c, 30);
        peek(10, c);
        chk("R5 later worse kept min", c, 30);
        peek(11, c);
        chk("R5 interleaved min", c, 45);
        peek(12, c);
        chk("R5 interleaved other", c, 70);
        chk("R7 burst single push", pushes[9], 1);
        chk("R7 interleaved single push", pushes[11], 1);
    endtask

    task automatic t_frame();
        int c;
        put_arc(5, 0, 0, 13);
        @(negedge clk);
        arc_valid   = 1'b0;
        frame_start = 1'b1;
        #1;
        chk("R8 ready low on frame start", int'(arc_ready), 0);
        @(negedge clk);
        frame_start = 1'b0;
        @(negedge clk);
        peek(13, c);
        chk("R8 in-flight arc cancelled", c, 65535);
        chk("R8 no push from cancelled arc", pushes[13], 0);
        peek(3, c);
        chk("R8 cost reset", c, 65535);
        peek(9, c);
        chk("R8 cost reset other", c, 65535);
        put_arc(80, 0, 0, 3);
        end_arcs();
        peek(3, c);
        chk("R8 new frame write", c, 80);
        chk("R8 push re-armed", pushes[3], 2);
    endtask

    initial begin
        for (int i = 0; i < N_STATES; i++) pushes[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_minimum();
        t_beam();
        t_saturate();
        t_hazard();
        t_frame();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #800000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule